// File: doc/BRIEF.md
# Tag-Only Cache Timing Controller

This block models the timing of a set-associative data cache without storing any data. Each set keeps a tag, a valid bit, a dirty bit and a recency age for every way. A requester presents a load or a store with a byte address. The controller looks up the set and reports whether the access hit, missed or displaced a resident block. It also reports how many cycles the access would have cost under a fixed memory model. Main memory moves 8-byte units: the first unit costs `MEM_CYC` and every further unit of the same block costs one more cycle. A block fill therefore costs `MEM_CYC + BLOCK_BYTES/8 - 1`.

Elaboration parameters set the geometry (`SETS`, `BLOCK_BYTES`, `WAYS`) and the victim choice (`LRU_MODE`: 1 for exact LRU, 0 for pseudo-random). They also set the write mode (`WRITE_BACK`: 1 for write-back, 0 for write-through) and the two latencies (`HIT_CYC`, `MEM_CYC`). Running totals of hits, misses, evictions, loads, stores and cycles are exposed as outputs. An access is assumed to lie inside one block, so the offset bits of the address are not used.

The controller is a three-state machine:
- `ST_IDLE` has `req_ready` high. Transition *accept* (`req_valid`) moves it to `ST_LOOK`.
- `ST_LOOK` resolves the lookup and updates tag, valid, dirty and age state in one cycle. Transition *resolve* (unconditional) moves it to `ST_RESP`.
- `ST_RESP` holds `rsp_valid` and the result. Transition *retire* (`rsp_ready`) returns it to `ST_IDLE` and updates the totals.

Top module: `tagcache_ctrl`

## Requirements
- R1: After reset `req_ready` is 1, `rsp_valid` is 0, all six totals read 0 and every way is invalid, so the first access to any set misses without eviction.
- R2: A request is taken in the cycle `req_valid` and `req_ready` are both high. The result appears with `rsp_valid` two clock edges later and stays unchanged until `rsp_ready`. Exactly one of `rsp_hit` and `rsp_miss` is set.
- R3: A load hit costs `HIT_CYC`. A load miss costs `HIT_CYC + MEM_CYC + BLOCK_BYTES/8 - 1`.
- R4: A store miss fetches the block first and then performs the store as a hit. It reports `rsp_miss`, and its cost is the load-miss cost plus the store-hit cost of the write mode.
- R5: With `WRITE_BACK`=1 a store hit costs `HIT_CYC` and marks the block dirty. With `WRITE_BACK`=0 every store hit costs `HIT_CYC + MEM_CYC` and no block becomes dirty.
- R6: A miss fills the lowest-numbered invalid way of the set without eviction if one exists. Otherwise it replaces a valid way and sets `rsp_evict`, which is never set on a hit.
- R7: With `WRITE_BACK`=1, replacing a dirty block adds `MEM_CYC + BLOCK_BYTES/8 - 1` cycles to the access. Replacing a clean block, or any block with `WRITE_BACK`=0, adds nothing.
- R8: With `LRU_MODE`=1 the victim is the way that has gone longest without a load or store touching it.
- R9: With `LRU_MODE`=0 the victim in a full set is taken from a free-running 16-bit LFSR that is seeded at reset and never reaches zero.
- R10: On each retire, `cnt_hits`, `cnt_misses` and `cnt_evicts` follow the flags. `cnt_reads` counts loads, `cnt_writes` counts stores, and `cnt_cycles` adds `rsp_cost`.
- R11: Address bits [log2(BLOCK_BYTES)-1:0] are ignored. The next log2(SETS) bits select the set and the rest form the tag, so equal tags in different sets do not interact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_store | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Byte address |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Requester takes the result |
| rsp_hit | output | 1 | Access hit |
| rsp_miss | output | 1 | Access missed |
| rsp_evict | output | 1 | A valid block was replaced |
| rsp_cost | output | COST_W | Cycle cost of the access |
| cnt_hits | output | CNT_W | Total hits |
| cnt_misses | output | CNT_W | Total misses |
| cnt_evicts | output | CNT_W | Total evictions |
| cnt_reads | output | CNT_W | Total loads |
| cnt_writes | output | CNT_W | Total stores |
| cnt_cycles | output | CNT_W | Sum of all costs |

## Verification
The assertions guard the per-cycle invariants on every cycle:
- a response carries exactly one outcome, and an eviction only accompanies a miss;
- a load hit always costs `HIT_CYC`, and a held response stays unchanged;
- the cycle total grows by exactly the retired cost;
- a free way is always chosen before a valid one;
- the LFSR never reaches zero.

Only the directed scenarios can show which way is chosen as the victim, because that depends on the history of the set. The same holds for the extra write-back cost of a dirty victim, the fetch-on-write cost of a store miss, and the difference between write-through and write-back store costs.

// File: rtl/tagcache_pkg.sv
package tagcache_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOOK = 2'd1,
        ST_RESP = 2'd2
    } tc_state_e;
endpackage

// File: rtl/tagcache_lfsr.sv
module tagcache_lfsr #(
    parameter int          OUT_W = 2,
    parameter logic [15:0] SEED  = 16'hACE1
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [OUT_W-1:0] rnd
);
    logic [15:0] lfsr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) lfsr_q <= SEED;
        else        lfsr_q <= {1'b0, lfsr_q[15:1]} ^ (lfsr_q[0] ? 16'hB400 : 16'h0000);
    end

    assign rnd = lfsr_q[OUT_W-1:0];

    AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_q != 16'h0000); // R9
endmodule

// File: rtl/tagcache_victim.sv
module tagcache_victim #(
    parameter int WAYS     = 4,
    parameter int WAY_W    = 2,
    parameter int AGE_W    = 2,
    parameter bit LRU_MODE = 1'b1
) (
    input  logic [WAYS-1:0]       valid,
    input  logic [WAYS*AGE_W-1:0] ages,
    input  logic [WAY_W-1:0]      rnd,
    output logic                  has_free,
    output logic [WAY_W-1:0]      victim
);
    logic [WAY_W-1:0] free_way;
    logic [WAY_W-1:0] lru_way;

    // lowest invalid way wins: scan from the top down
    always_comb begin
        has_free = 1'b0;
        free_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!valid[w]) begin
                has_free = 1'b1;
                free_way = WAY_W'(w);
            end
        end
    end

    // oldest way carries age WAYS-1
    always_comb begin
        lru_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (ages[w*AGE_W +: AGE_W] == AGE_W'(WAYS - 1)) lru_way = WAY_W'(w);
        end
    end

    assign victim = has_free ? free_way : (LRU_MODE ? lru_way : rnd);
endmodule

// File: rtl/tagcache_ctrl.sv
module tagcache_ctrl
    import tagcache_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int SETS        = 8,
    parameter int BLOCK_BYTES = 16,
    parameter int WAYS        = 4,
    parameter bit LRU_MODE    = 1'b1,
    parameter bit WRITE_BACK  = 1'b1,
    parameter int HIT_CYC     = 13,
    parameter int MEM_CYC     = 230,
    parameter int COST_W      = 16,
    parameter int CNT_W       = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_store,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic              rsp_hit,
    output logic              rsp_miss,
    output logic              rsp_evict,
    output logic [COST_W-1:0] rsp_cost,
    output logic [CNT_W-1:0]  cnt_hits,
    output logic [CNT_W-1:0]  cnt_misses,
    output logic [CNT_W-1:0]  cnt_evicts,
    output logic [CNT_W-1:0]  cnt_reads,
    output logic [CNT_W-1:0]  cnt_writes,
    output logic [CNT_W-1:0]  cnt_cycles
);
    localparam int OFF_W    = $clog2(BLOCK_BYTES);
    localparam int IDX_W    = $clog2(SETS);
    localparam int TAG_W    = ADDR_W - OFF_W - IDX_W;
    localparam int LINE_W   = ADDR_W - OFF_W;
    localparam int WAY_W    = (WAYS > 1) ? $clog2(WAYS) : 1;
    localparam int AGE_W    = WAY_W;
    localparam int FILL_CYC = MEM_CYC + BLOCK_BYTES / 8 - 1;

    tc_state_e state_q, state_d;

    logic [LINE_W-1:0] line_q;
    logic              store_q;
    logic              unused_offset;

    logic [WAYS-1:0]  vld_q [SETS];
    logic [WAYS-1:0]  drt_q [SETS];
    logic [TAG_W-1:0] tag_q [SETS][WAYS];
    logic [AGE_W-1:0] age_q [SETS][WAYS];

    logic              hit_q, miss_q, evict_q;
    logic [COST_W-1:0] cost_q;

    logic [IDX_W-1:0]      idx;
    logic [TAG_W-1:0]      tg;
    logic [WAYS-1:0]       hit_vec;
    logic                  any_hit;
    logic [WAY_W-1:0]      hit_way;
    logic [WAY_W-1:0]      victim;
    logic                  has_free;
    logic [WAY_W-1:0]      fill_way;
    logic                  evict_d;
    logic                  dirty_victim;
    logic [WAYS*AGE_W-1:0] ages_flat;
    logic [WAY_W-1:0]      rnd;
    logic [COST_W-1:0]     cost_d;
    logic                  accept, retire;

    assign unused_offset = ^req_addr[OFF_W-1:0];

    // ---------------- lookup -------------------------------------------
    assign idx = line_q[IDX_W-1:0];
    assign tg  = line_q[LINE_W-1:IDX_W];

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign hit_vec[w] = vld_q[idx][w] && (tag_q[idx][w] == tg);
        assign ages_flat[w*AGE_W +: AGE_W] = age_q[idx][w];
    end

    always_comb begin
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (hit_vec[w]) hit_way = WAY_W'(w);
        end
    end
    assign any_hit = |hit_vec;

    tagcache_lfsr #(.OUT_W(WAY_W)) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .rnd   (rnd)
    );

    tagcache_victim #(
        .WAYS     (WAYS),
        .WAY_W    (WAY_W),
        .AGE_W    (AGE_W),
        .LRU_MODE (LRU_MODE)
    ) u_victim (
        .valid    (vld_q[idx]),
        .ages     (ages_flat),
        .rnd      (rnd),
        .has_free (has_free),
        .victim   (victim)
    );

    assign fill_way     = any_hit ? hit_way : victim;
    assign evict_d      = !any_hit && !has_free;
    assign dirty_victim = evict_d && drt_q[idx][victim] && WRITE_BACK;

    always_comb begin
        int unsigned c;
        c = HIT_CYC;
        if (!any_hit)     c = c + FILL_CYC;
        if (dirty_victim) c = c + FILL_CYC;
        if (store_q) begin
            if (!any_hit)    c = c + HIT_CYC;
            if (!WRITE_BACK) c = c + MEM_CYC;
        end
        cost_d = COST_W'(c);
    end

    // ---------------- state machine -------------------------------------
    assign accept = (state_q == ST_IDLE) && req_valid;
    assign retire = (state_q == ST_RESP) && rsp_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid) state_d = ST_LOOK;
            ST_LOOK: state_d = ST_RESP;
            ST_RESP: if (rsp_ready) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        req_ready = (state_q == ST_IDLE);
        rsp_valid = (state_q == ST_RESP);
        rsp_hit   = hit_q;
        rsp_miss  = miss_q;
        rsp_evict = evict_q;
        rsp_cost  = cost_q;
    end

    // ---------------- request and result registers ----------------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q  <= '0;
            store_q <= 1'b0;
            hit_q   <= 1'b0;
            miss_q  <= 1'b0;
            evict_q <= 1'b0;
            cost_q  <= '0;
        end else begin
            if (accept) begin
                line_q  <= req_addr[ADDR_W-1:OFF_W];
                store_q <= req_store;
            end
            if (state_q == ST_LOOK) begin
                hit_q   <= any_hit;
                miss_q  <= !any_hit;
                evict_q <= evict_d;
                cost_q  <= cost_d;
            end
        end
    end

    // ---------------- tag, valid, dirty, age state ----------------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                vld_q[s] <= '0;
                drt_q[s] <= '0;
                for (int w = 0; w < WAYS; w++) begin
                    tag_q[s][w] <= '0;
                    age_q[s][w] <= AGE_W'(w);
                end
            end
        end else if (state_q == ST_LOOK) begin
            vld_q[idx][fill_way] <= 1'b1;
            tag_q[idx][fill_way] <= tg;
            if (WRITE_BACK && store_q) drt_q[idx][fill_way] <= 1'b1;
            else if (!any_hit)         drt_q[idx][fill_way] <= 1'b0;
            for (int w = 0; w < WAYS; w++) begin
                if (WAY_W'(w) == fill_way)
                    age_q[idx][w] <= '0;
                else if (age_q[idx][w] < age_q[idx][fill_way])
                    age_q[idx][w] <= age_q[idx][w] + 1'b1;
            end
        end
    end

    // ---------------- running totals ------------------------------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_hits   <= '0;
            cnt_misses <= '0;
            cnt_evicts <= '0;
            cnt_reads  <= '0;
            cnt_writes <= '0;
            cnt_cycles <= '0;
        end else if (retire) begin
            cnt_hits   <= cnt_hits   + CNT_W'(hit_q);
            cnt_misses <= cnt_misses + CNT_W'(miss_q);
            cnt_evicts <= cnt_evicts + CNT_W'(evict_q);
            cnt_reads  <= cnt_reads  + CNT_W'(!store_q);
            cnt_writes <= cnt_writes + CNT_W'(store_q);
            cnt_cycles <= cnt_cycles + CNT_W'(cost_q);
        end
    end

    // ---------------- assertions ----------------------------------------
    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_hit ^ rsp_miss)); // R2
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_cost) && $stable(rsp_hit))); // R2
    AST_NO_EVICT_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_evict) |-> rsp_miss); // R6
    AST_LOAD_HIT_COST: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit && !store_q) |-> (rsp_cost == COST_W'(HIT_CYC))); // R3
    AST_FREE_WAY_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOOK && !any_hit && has_free) |-> !vld_q[idx][victim]); // R6
    AST_CYCLE_TOTAL: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_ready) |=> (cnt_cycles == $past(cnt_cycles) + CNT_W'($past(rsp_cost)))); // R10
endmodule

// File: tb/tagcache_ctrl_test.sv
`timescale 1ns/1ps
module tagcache_ctrl_test;
    localparam int HIT  = 13;
    localparam int MEM  = 230;
    localparam int FILL = MEM + 16/8 - 1;   // 231

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic        req_store = 1'b0;
    logic [31:0] req_addr  = '0;
    logic        rsp_ready = 1'b1;
    logic        va = 1'b0, vb = 1'b0;

    logic        ra_rdy, ra_vld, ra_hit, ra_miss, ra_ev;
    logic [15:0] ra_cost;
    logic [31:0] ca_h, ca_m, ca_e, ca_r, ca_w, ca_c;
    logic        rb_rdy, rb_vld, rb_hit, rb_miss, rb_ev;
    logic [15:0] rb_cost;
    logic [31:0] cb_h, cb_m, cb_e, cb_r, cb_w, cb_c;

    tagcache_ctrl uut (
        .clk(clk), .rst_n(rst_n), .req_valid(va), .req_ready(ra_rdy),
        .req_store(req_store), .req_addr(req_addr), .rsp_valid(ra_vld),
        .rsp_ready(rsp_ready), .rsp_hit(ra_hit), .rsp_miss(ra_miss),
        .rsp_evict(ra_ev), .rsp_cost(ra_cost), .cnt_hits(ca_h),
        .cnt_misses(ca_m), .cnt_evicts(ca_e), .cnt_reads(ca_r),
        .cnt_writes(ca_w), .cnt_cycles(ca_c));

    tagcache_ctrl #(.LRU_MODE(1'b0), .WRITE_BACK(1'b0)) uut_wt (
        .clk(clk), .rst_n(rst_n), .req_valid(vb), .req_ready(rb_rdy),
        .req_store(req_store), .req_addr(req_addr), .rsp_valid(rb_vld),
        .rsp_ready(rsp_ready), .rsp_hit(rb_hit), .rsp_miss(rb_miss),
        .rsp_evict(rb_ev), .rsp_cost(rb_cost), .cnt_hits(cb_h),
        .cnt_misses(cb_m), .cnt_evicts(cb_e), .cnt_reads(cb_r),
        .cnt_writes(cb_w), .cnt_cycles(cb_c));

    int checks = 0, errors = 0;
    int m_h = 0, m_m = 0, m_e = 0, m_r = 0, m_w = 0, m_c = 0;
    bit done = 1'b0;

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input int tag, input int set, input int off);
        return 32'((tag << 7) | (set << 4) | off);
    endfunction

    // one access on instance sel, checked against expected flags and cost
    task automatic txn(input bit sel, input bit st, input logic [31:0] a,
                       input bit e_hit, input bit e_ev, input int e_cost, input string req);
        int wait_n = 0;
        @(negedge clk);
        req_store = st; req_addr = a;
        if (sel) vb = 1'b1; else va = 1'b1;
        @(negedge clk);
        va = 1'b0; vb = 1'b0;
        @(negedge clk);
        wait_n = 2;
        if (sel) begin
            chk({req, " R2 valid"}, rb_vld, 1);
            chk({req, " hit"},   rb_hit, e_hit);
            chk({req, " evict"}, rb_ev, e_ev);
            chk({req, " cost"},  rb_cost, e_cost);
        end else begin
            chk({req, " R2 valid"}, ra_vld, 1);
            chk({req, " hit"},   ra_hit, e_hit);
            chk({req, " evict"}, ra_ev, e_ev);
            chk({req, " cost"},  ra_cost, e_cost);
            m_h += e_hit; m_m += !e_hit; m_e += e_ev;
            m_r += !st; m_w += st; m_c += e_cost;
        end
        @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R1 req_ready", ra_rdy, 1);
        chk("R1 rsp_valid", ra_vld, 0);
        chk("R1 cnt_cycles", ca_c, 0);
        chk("R1 cnt_hits", ca_h, 0);
        chk("R1 cnt_reads", ca_r, 0);
    endtask

    task automatic t_hold;
        // R2: result held while rsp_ready is low
        @(negedge clk);
        rsp_ready = 1'b0; req_store = 1'b0; req_addr = mk(9, 6, 0); va = 1'b1;
        @(negedge clk); va = 1'b0;
        repeat (3) @(negedge clk);
        chk("R2 held valid", ra_vld, 1);
        chk("R2 held cost", ra_cost, HIT + FILL);
        chk("R2 ready low while busy", ra_rdy, 0);
        rsp_ready = 1'b1;
        m_m += 1; m_r += 1; m_c += HIT + FILL;
        @(negedge clk);
        chk("R2 back to idle", ra_rdy, 1);
    endtask

    task automatic t_lru_wb;
        txn(0, 0, mk(1, 1, 3), 0, 0, HIT + FILL, "R3 R1 load miss A");
        txn(0, 0, mk(1, 1, 9), 1, 0, HIT,        "R3 R11 load hit A other offset");
        txn(0, 1, mk(1, 1, 0), 1, 0, HIT,        "R5 wb store hit A");
        txn(0, 0, mk(2, 1, 0), 0, 0, HIT + FILL, "R6 fill B free way");
        txn(0, 0, mk(3, 1, 0), 0, 0, HIT + FILL, "R6 fill C free way");
        txn(0, 0, mk(4, 1, 0), 0, 0, HIT + FILL, "R6 fill D free way");
        txn(0, 0, mk(1, 1, 0), 1, 0, HIT,        "R8 touch A");
        txn(0, 0, mk(5, 1, 0), 0, 1, HIT + FILL, "R8 E evicts B");
        txn(0, 0, mk(2, 1, 0), 0, 1, HIT + FILL, "R8 B gone, evicts C");
        txn(0, 0, mk(1, 1, 0), 1, 0, HIT,        "R8 A kept");
        txn(0, 0, mk(4, 1, 0), 1, 0, HIT,        "R8 D kept");
        txn(0, 1, mk(6, 1, 0), 0, 1, HIT + FILL + HIT, "R4 store miss F evicts E");
        txn(0, 0, mk(2, 1, 0), 1, 0, HIT,        "R8 touch B");
        txn(0, 0, mk(7, 1, 0), 0, 1, HIT + FILL + FILL, "R7 G evicts dirty A");
        txn(0, 0, mk(1, 1, 0), 0, 1, HIT + FILL, "R7 A reload evicts clean D");
        txn(0, 0, mk(6, 1, 0), 1, 0, HIT,        "R8 F kept");
        txn(0, 0, mk(1, 4, 0), 0, 0, HIT + FILL, "R11 same tag other set");
    endtask

    task automatic t_wt_random;
        txn(1, 1, mk(1, 2, 0), 0, 0, HIT + FILL + HIT + MEM, "R4 wt store miss");
        txn(1, 1, mk(1, 2, 0), 1, 0, HIT + MEM,  "R5 wt store hit");
        txn(1, 0, mk(1, 2, 0), 1, 0, HIT,        "R3 wt load hit");
        txn(1, 0, mk(2, 2, 0), 0, 0, HIT + FILL, "R6 wt fill 2");
        txn(1, 0, mk(3, 2, 0), 0, 0, HIT + FILL, "R6 wt fill 3");
        txn(1, 0, mk(4, 2, 0), 0, 0, HIT + FILL, "R6 wt fill 4");
        for (int t = 5; t < 9; t++)
            txn(1, 0, mk(t, 2, 0), 0, 1, HIT + FILL, "R9 R7 random evict no writeback");
        txn(1, 0, mk(8, 2, 0), 1, 0, HIT,        "R9 newest block resident");
        chk("R10 wt writes", cb_w, 2);
    endtask

    task automatic t_totals;
        chk("R10 hits",   ca_h, m_h);
        chk("R10 misses", ca_m, m_m);
        chk("R10 evicts", ca_e, m_e);
        chk("R10 reads",  ca_r, m_r);
        chk("R10 writes", ca_w, m_w);
        chk("R10 cycles", ca_c, m_c);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_lru_wb();
        t_hold();
        t_wt_random();
        t_totals();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule